// File: doc/BRIEF.md
# ALU with Condition Codes

This block is the 8-bit data path of a small controller core. It combines two operands under an operation code into a result. It then updates a five-bit flag register holding half carry, interrupt mask, negative, zero and carry. The flag register supplies the carry-in for add-with-carry and for the rotates. The result is combinational and comes with a write-enable, so the core knows whether to store it.

The same register also holds the interrupt mask. Two pending latches, one for the external request and one for the timer request, sit beside it. A request is caught at any time. It is presented to the core only while the mask is clear, and it stays pending until the core acknowledges it. Instruction sequencing and vector fetch belong to the core, not to this block.

Top module: `cc_alu`

## Requirements
- R1: `ccr` packs the flags as bit 4 = H, bit 3 = I, bit 2 = N, bit 1 = Z, bit 0 = C. Reset sets I, clears H, N, Z and C, and clears both pending requests.
- R2: With `exec` high, `op` selects 0 ADD, 1 ADC (a+b+C), 2 SUB, 3 CMP, 4 AND, 5 OR, 6 XOR, 7 LSL, 8 LSR, 9 ASR, 10 ROL, 11 ROR, 12 INC, 13 DEC, 14 CLR, 15 COM, 16 TST, 17 BIT. `result` gives a op b for the binary codes and the operation applied to `a` for the unary codes.
- R3: H takes the carry from bit 3 into bit 4 on ADD and ADC only. Every other code leaves H unchanged.
- R4: For every code except BIT, N takes bit 7 of the result and Z is set when the result is zero. TST uses `a` as its result.
- R5: C takes the carry out on ADD and ADC. On SUB and CMP it is set when `b` exceeds `a` unsigned. LSL moves bit 7 into C; LSR and ASR move bit 0 into C. COM sets C. AND, OR, XOR, INC, DEC, CLR and TST leave C unchanged.
- R6: ROL fills bit 0 with the old C and moves bit 7 into C. ROR fills bit 7 with the old C and moves bit 0 into C.
- R7: `wr_en` is low for CMP, TST, BIT and unused codes, and high otherwise. BIT copies `a[bit_sel]` into C and leaves H, N and Z unchanged.
- R8: With `exec` low, H, N, Z and C hold their values.
- R9: `set_mask` sets I and `clr_mask` clears it at the next edge. When both are high, `set_mask` wins.
- R10: While I is set, `ext_irq` and `tmr_irq` stay low, but requests are still latched. A request latched while masked appears on its output in the cycle after I clears.
- R11: An acknowledge clears its pending request at the next edge. A new request in the same cycle as its acknowledge keeps the request pending.
- R12: The external and timer pending latches are independent. A request or acknowledge on one never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Apply the operation's flag update at the next edge |
| op | input | 5 | Operation code (R2) |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| bit_sel | input | 3 | Bit index for BIT |
| set_mask | input | 1 | Set the interrupt mask |
| clr_mask | input | 1 | Clear the interrupt mask |
| ext_req | input | 1 | External interrupt request pulse |
| tmr_req | input | 1 | Timer interrupt request pulse |
| ext_ack | input | 1 | External request acknowledged |
| tmr_ack | input | 1 | Timer request acknowledged |
| result | output | 8 | Combinational result |
| wr_en | output | 1 | Result is to be stored |
| ccr | output | 5 | Flag register {H,I,N,Z,C} |
| ext_irq | output | 1 | Unmasked pending external request |
| tmr_irq | output | 1 | Unmasked pending timer request |

## Verification
The mask and the pending latches interact with the request and acknowledge pulses. A new request can land in the same cycle as the acknowledge of the one before, and a mask change can land with a request. The bench drives these pairs together in one cycle: request with acknowledge, set with clear of the mask, and a request with a clear of the mask. In the following cycle it compares both interrupt outputs and `ccr` against a model queued by the driver. The same queue also checks that flag updates from arithmetic in that cycle proceed alongside the interrupt updates.

// File: rtl/cc_alu.sv
module cc_alu #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec,
  input  logic [4:0]           op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [$clog2(W)-1:0] bit_sel,
  input  logic                 set_mask,
  input  logic                 clr_mask,
  input  logic                 ext_req,
  input  logic                 tmr_req,
  input  logic                 ext_ack,
  input  logic                 tmr_ack,
  output logic [W-1:0]         result,
  output logic                 wr_en,
  output logic [4:0]           ccr,
  output logic                 ext_irq,
  output logic                 tmr_irq
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_CMP = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_LSL = 5'd7;
  localparam logic [4:0] OP_LSR = 5'd8,  OP_ASR = 5'd9,  OP_ROL = 5'd10, OP_ROR = 5'd11;
  localparam logic [4:0] OP_INC = 5'd12, OP_DEC = 5'd13, OP_CLR = 5'd14, OP_COM = 5'd15;
  localparam logic [4:0] OP_TST = 5'd16, OP_BIT = 5'd17;

  logic h_q, i_q, n_q, z_q, c_q;
  logic pend_ext, pend_tmr;
  logic [W-1:0] res;
  logic         h_nx, c_nx, nz_upd, wr;
  logic [W:0]   wide;
  logic [4:0]   low;

  always_comb begin
    res    = a;
    h_nx   = h_q;
    c_nx   = c_q;
    nz_upd = 1'b1;
    wr     = 1'b1;
    wide   = '0;
    low    = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (op == OP_ADC) & c_q};
        low  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, (op == OP_ADC) & c_q};
        res  = wide[W-1:0];
        c_nx = wide[W];
        h_nx = low[4];
      end
      OP_SUB, OP_CMP: begin
        res  = a - b;
        c_nx = b > a;
        wr   = (op == OP_SUB);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_LSL: begin res = {a[W-2:0], 1'b0};     c_nx = a[W-1]; end
      OP_LSR: begin res = {1'b0, a[W-1:1]};     c_nx = a[0];   end
      OP_ASR: begin res = {a[W-1], a[W-1:1]};   c_nx = a[0];   end
      OP_ROL: begin res = {a[W-2:0], c_q};      c_nx = a[W-1]; end
      OP_ROR: begin res = {c_q, a[W-1:1]};      c_nx = a[0];   end
      OP_INC: res = a + 1'b1;
      OP_DEC: res = a - 1'b1;
      OP_CLR: res = '0;
      OP_COM: begin res = ~a; c_nx = 1'b1; end
      OP_TST: wr = 1'b0;
      OP_BIT: begin c_nx = a[bit_sel]; nz_upd = 1'b0; wr = 1'b0; end
      default: begin nz_upd = 1'b0; wr = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= 1'b0; i_q <= 1'b1; n_q <= 1'b0; z_q <= 1'b0; c_q <= 1'b0;
      pend_ext <= 1'b0; pend_tmr <= 1'b0;
    end else begin
      if (exec) begin
        h_q <= h_nx;
        c_q <= c_nx;
        if (nz_upd) begin
          n_q <= res[W-1];
          z_q <= (res == '0);
        end
      end
      if (set_mask)      i_q <= 1'b1;
      else if (clr_mask) i_q <= 1'b0;
      if (ext_req)       pend_ext <= 1'b1;
      else if (ext_ack)  pend_ext <= 1'b0;
      if (tmr_req)       pend_tmr <= 1'b1;
      else if (tmr_ack)  pend_tmr <= 1'b0;
    end
  end

  assign result  = res;
  assign wr_en   = wr;
  assign ccr     = {h_q, i_q, n_q, z_q, c_q};
  assign ext_irq = pend_ext & ~i_q;
  assign tmr_irq = pend_tmr & ~i_q;

  // R3
  h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_ADD && op != OP_ADC) |=> $stable(ccr[4]));
  // R10
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccr[3] |-> (!ext_irq && !tmr_irq));
  // R10
  req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |=> (ext_irq || ccr[3]));
  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ack && !tmr_req) |=> !tmr_irq);
  // R5
  cmp_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_CMP) |=> (ccr[0] == ($past(b) > $past(a))));
  // R8
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(ccr[4]) && $stable(ccr[2:0])));
  // R9
  mask_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_mask |=> ccr[3]);
endmodule

// File: tb/cc_alu_bench.sv
module cc_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exec = 0, set_mask = 0, clr_mask = 0;
  logic ext_req = 0, tmr_req = 0, ext_ack = 0, tmr_ack = 0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] result;
  logic wr_en, ext_irq, tmr_irq;
  logic [4:0] ccr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic mh = 0, mi = 1, mn = 0, mz = 0, mc = 0, mpe = 0, mpt = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  cc_alu u_cc_alu (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({ccr, ext_irq, tmr_irq} === e, t, {1'b0, ccr, ext_irq, tmr_irq}, {1'b0, e});
    end
  end

  task automatic step(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                      input logic [2:0] bs, input bit ex, input bit sm, input bit cm,
                      input bit er, input bit tr, input bit ea, input bit ta, input string tag);
    logic [7:0] r;
    logic [8:0] s;
    logic nh, nc, w, upd;
    @(negedge clk);
    op = o; a = x; b = y; bit_sel = bs; exec = ex;
    set_mask = sm; clr_mask = cm; ext_req = er; tmr_req = tr; ext_ack = ea; tmr_ack = ta;
    r = x; nh = mh; nc = mc; w = 1; upd = 1;
    case (o)
      0, 1: begin
        s = {1'b0, x} + {1'b0, y} + ((o == 1) ? {8'd0, mc} : 9'd0);
        r = s[7:0]; nc = s[8];
        nh = (({1'b0, x[3:0]} + {1'b0, y[3:0]} + ((o == 1) ? {4'd0, mc} : 5'd0)) > 5'd15);
      end
      2, 3: begin r = x - y; nc = (y > x); w = (o == 2); end
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      7: begin r = x << 1; nc = x[7]; end
      8: begin r = x >> 1; nc = x[0]; end
      9: begin r = {x[7], x[7:1]}; nc = x[0]; end
      10: begin r = {x[6:0], mc}; nc = x[7]; end
      11: begin r = {mc, x[7:1]}; nc = x[0]; end
      12: r = x + 8'd1;
      13: r = x - 8'd1;
      14: r = 8'd0;
      15: begin r = ~x; nc = 1'b1; end
      16: w = 0;
      17: begin nc = x[bs]; upd = 0; w = 0; end
      default: begin upd = 0; w = 0; end
    endcase
    #1;
    if (ex) begin
      chk(wr_en === w, {tag, " wr_en"}, {7'd0, wr_en}, {7'd0, w});
      if (w) chk(result === r, {tag, " result"}, result, r);
      mh = nh; mc = nc;
      if (upd) begin mn = r[7]; mz = (r == 8'd0); end
    end
    if (sm) mi = 1; else if (cm) mi = 0;
    if (er) mpe = 1; else if (ea) mpe = 0;
    if (tr) mpt = 1; else if (ta) mpt = 0;
    exp_q.push_back({mh, mi, mn, mz, mc, mpe & ~mi, mpt & ~mi});
    tag_q.push_back({tag, " ccr/irq"});
  endtask

  task automatic alu(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y, input string tag);
    step(o, x, y, 3'd0, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic irq(input bit sm, input bit cm, input bit er, input bit tr,
                     input bit ea, input bit ta, input string tag);
    step(5'd0, 8'd0, 8'd0, 3'd0, 0, sm, cm, er, tr, ea, ta, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ccr === 5'b01000 && !ext_irq && !tmr_irq, "R1 reset", {1'b0, ccr, ext_irq, tmr_irq}, 8'h20);
    rst_n = 1'b1;
    // R10: requests while masked stay hidden, then appear after the mask clears
    irq(0, 0, 1, 0, 0, 0, "R10 ext masked");
    irq(0, 0, 0, 1, 0, 0, "R10 tmr masked");
    irq(0, 1, 0, 0, 0, 0, "R10 unmask");
    // R11 / R12
    irq(0, 0, 0, 0, 1, 0, "R11 ext ack");
    irq(0, 0, 1, 0, 0, 1, "R12 ext req tmr ack");
    irq(0, 0, 1, 0, 1, 0, "R11 req with ack");
    irq(1, 1, 0, 0, 1, 0, "R9 set wins");
    irq(0, 1, 0, 1, 0, 0, "R10 unmask with req");
    irq(0, 0, 0, 0, 0, 1, "R11 tmr ack");
    // arithmetic
    alu(0, 8'h0F, 8'h01, "R3 add half carry");
    alu(0, 8'hFF, 8'h01, "R4 add zero carry");
    alu(1, 8'h10, 8'h20, "R2 adc");
    alu(1, 8'h08, 8'h07, "R3 adc half");
    alu(2, 8'h10, 8'h20, "R5 sub borrow");
    alu(3, 8'h05, 8'h05, "R7 cmp equal");
    alu(3, 8'h04, 8'h09, "R5 cmp borrow");
    alu(4, 8'hF0, 8'h3C, "R2 and");
    alu(5, 8'h80, 8'h01, "R2 or");
    alu(6, 8'hAA, 8'hAA, "R4 xor zero");
    alu(7, 8'h81, 8'h00, "R5 lsl");
    alu(8, 8'h01, 8'h00, "R5 lsr");
    alu(9, 8'h82, 8'h00, "R5 asr");
    alu(10, 8'h40, 8'h00, "R6 rol");
    alu(11, 8'h01, 8'h00, "R6 ror");
    alu(11, 8'h00, 8'h00, "R6 ror carry in");
    alu(12, 8'hFF, 8'h00, "R5 inc keeps C");
    alu(13, 8'h00, 8'h00, "R4 dec");
    alu(14, 8'h55, 8'h00, "R2 clr");
    alu(15, 8'h0F, 8'h00, "R5 com");
    alu(16, 8'h80, 8'h00, "R4 tst");
    step(17, 8'h20, 8'h00, 3'd5, 1, 0, 0, 0, 0, 0, 0, "R7 bit set");
    step(17, 8'h20, 8'h00, 3'd4, 1, 0, 0, 0, 0, 0, 0, "R7 bit clear");
    alu(5'd25, 8'h00, 8'h00, "R7 unused code");
    step(0, 8'h0F, 8'h0F, 3'd0, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
    step(0, 8'h08, 8'h08, 3'd0, 1, 0, 0, 1, 1, 0, 0, "R12 add with requests");
    irq(0, 0, 0, 0, 1, 1, "R11 ack both");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule